// File: doc/BRIEF.md
# SRAM Page Pointer Selection Unit

This unit sits between a small CPU core and a data SRAM that is split into 256-byte pages. The CPU presents an 8-bit offset, an access-kind code, a two-bit paging-mode field and the number of its current page. The unit adds a 3-bit page number to the offset and passes the 11-bit physical address to the SRAM as a registered request. It holds three page pointers, one each for stack, indexed and indirect-read accesses. Software loads them over a simple register write/read port.

The indirect read runs in two phases. First a pointer byte is fetched from the current page at the given offset. That byte then becomes the offset of a data read in the indirect-read page. A one-cycle done strobe marks the SRAM handshake cycle in which the data byte is on `mem_rdata`.

Requests enter on a valid/ready pair (`acc_valid`/`acc_ready`), and SRAM requests leave on a valid/ready pair (`mem_valid`/`mem_ready`). While `mem_ready` is low, the outstanding request holds `mem_valid` and keeps `mem_addr` unchanged. `acc_ready` is high only when no indirect sequence is running and the output register is empty or is being drained in the same cycle. A back-pressured SRAM therefore stalls the CPU without losing or reordering accesses. Read data for a request is on `mem_rdata` in the cycle that request completes its handshake.

Top module: `sram_page_mapper`

## Requirements
- R1: After reset all three page pointers read 0, `mem_valid` is low and `ind_done` is low.
- R2: The stack pointer is at register address D1h, the index pointer at D3h and the indirect-read pointer at D4h. A write stores `reg_wdata[2:0]` and ignores bits [7:3]. A read returns the stored page in bits [2:0] and zeros in bits [7:3]. Any other address reads 0x00, and a write to it changes no pointer.
- R3: A stack access (kind code 1) uses the stack pointer's page for every paging-mode value. A pointer write takes effect on the first access accepted after the write edge.
- R4: A source-indexed access (kind 2) or destination-indexed access (kind 3) uses the index pointer's page when the mode is 10b. It uses the stack pointer's page when the mode is 11b, and page 0 when the mode is 00b or 01b.
- R5: A direct access (kind 0) and the unused kind codes 5 to 7 use `cur_page`.
- R6: An indirect read (kind 4) first requests address {cur_page, offset}. After that handshake it requests {indirect-read page, pointer byte}, where the pointer byte is the value of `mem_rdata` in the first handshake cycle. The paging-mode field has no effect on either phase.
- R7: `ind_done` is high for exactly the cycle in which the second phase of an indirect read completes its handshake, and low at all other times.
- R8: The address leaves on `mem_addr` as {page[2:0], offset[7:0]}, registered: it appears with `mem_valid` in the cycle after acceptance. It stays unchanged while `mem_valid` is high and `mem_ready` is low.
- R9: `acc_ready` is low throughout both phases of an indirect read. Otherwise it is high exactly when `mem_valid` is low or `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Pointer register write strobe |
| reg_addr | input | 8 | Pointer register address |
| reg_wdata | input | 8 | Pointer register write data |
| reg_rdata | output | 8 | Pointer register read data for reg_addr |
| acc_valid | input | 1 | CPU access request valid |
| acc_ready | output | 1 | Unit can accept an access this cycle |
| acc_kind | input | 3 | Access kind: 0 direct, 1 stack, 2 source-indexed, 3 destination-indexed, 4 indirect read |
| acc_offset | input | 8 | Offset within a page |
| page_mode | input | 2 | Paging-mode field from the CPU flags |
| cur_page | input | 3 | CPU current page |
| mem_valid | output | 1 | SRAM request valid |
| mem_ready | input | 1 | SRAM accepts the request |
| mem_addr | output | 11 | Physical SRAM address |
| mem_rdata | input | 8 | SRAM read data, valid in the handshake cycle |
| ind_done | output | 1 | Indirect-read data byte is valid on mem_rdata |

## Verification
A register write takes effect at its edge. Read data depends only on the address, so the bench samples `reg_rdata` one settle delay after it drives `reg_addr` at a falling edge. An access accepted at rising edge N shows its address on `mem_addr` from just after edge N. The bench samples at the falling edge after N, and again at every stalled falling edge, until it drives `mem_ready` high. For an indirect read, the data-phase address appears after the pointer handshake edge, and `ind_done` is checked combinationally in the falling-edge window of the data handshake. `acc_ready` is compared in every one of those windows against the value R9 predicts for the phase and the `mem_ready` level the bench drives.

// File: rtl/sram_pp_pkg.sv
package sram_pp_pkg;

  typedef enum logic [2:0] {
    ACC_DIRECT  = 3'd0,
    ACC_STACK   = 3'd1,
    ACC_SRC_IDX = 3'd2,
    ACC_DST_IDX = 3'd3,
    ACC_IND_RD  = 3'd4
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_PTR_FETCH = 2'd1,
    ST_DATA_READ = 2'd2
  } seq_state_e;

  localparam logic [1:0] MODE_IDX_PAGE = 2'b10;
  localparam logic [1:0] MODE_STK_PAGE = 2'b11;

  localparam int NUM_PTR = 3;
  localparam int PTR_STK = 0;
  localparam int PTR_IDX = 1;
  localparam int PTR_IND = 2;

endpackage

// File: rtl/sram_pp_regs.sv
module sram_pp_regs
  import sram_pp_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int REG_W  = 8,
  parameter logic [REG_W-1:0] STK_ADDR = 8'hD1,
  parameter logic [REG_W-1:0] IDX_ADDR = 8'hD3,
  parameter logic [REG_W-1:0] IND_ADDR = 8'hD4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [PAGE_W-1:0] stk_page,
  output logic [PAGE_W-1:0] idx_page,
  output logic [PAGE_W-1:0] ind_page
);

  localparam logic [REG_W-1:0] PTR_ADDR [NUM_PTR] = '{STK_ADDR, IDX_ADDR, IND_ADDR};

  logic [PAGE_W-1:0] ptr_q [NUM_PTR];
  logic [NUM_PTR-1:0] hit;

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    assign hit[i] = (addr == PTR_ADDR[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr_q[i] <= '0;
      end else if (wr_en && hit[i]) begin
        ptr_q[i] <= wdata[PAGE_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (hit[i]) rdata[PAGE_W-1:0] = ptr_q[i];
    end
  end

  assign stk_page = ptr_q[PTR_STK];
  assign idx_page = ptr_q[PTR_IDX];
  assign ind_page = ptr_q[PTR_IND];

  AST_STK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == STK_ADDR) |=> (stk_page == $past(wdata[PAGE_W-1:0]))); // R2

  AST_IND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == IND_ADDR) |=> $stable(ind_page)); // R2

endmodule

// File: rtl/sram_pp_select.sv
module sram_pp_select
  import sram_pp_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic [2:0]        kind,
  input  logic [1:0]        mode,
  input  logic [PAGE_W-1:0] cur_page,
  input  logic [PAGE_W-1:0] stk_page,
  input  logic [PAGE_W-1:0] idx_page,
  output logic [PAGE_W-1:0] page
);

  logic [PAGE_W-1:0] indexed_page;

  always_comb begin
    unique case (mode)
      MODE_IDX_PAGE: indexed_page = idx_page;
      MODE_STK_PAGE: indexed_page = stk_page;
      default:       indexed_page = '0;
    endcase
  end

  always_comb begin
    case (kind)
      ACC_STACK:                page = stk_page;
      ACC_SRC_IDX, ACC_DST_IDX: page = indexed_page;
      default:                  page = cur_page;
    endcase
  end

endmodule

// File: rtl/sram_pp_seq.sv
module sram_pp_seq
  import sram_pp_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int OFF_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic [2:0]              acc_kind,
  input  logic [OFF_W-1:0]        acc_offset,
  input  logic [PAGE_W-1:0]       sel_page,
  input  logic [PAGE_W-1:0]       ind_page,
  output logic                    acc_ready,
  input  logic                    mem_ready,
  input  logic [OFF_W-1:0]        mem_rdata,
  output logic                    mem_valid,
  output logic [PAGE_W+OFF_W-1:0] mem_addr,
  output logic                    ind_done
);

  seq_state_e state_q;
  logic acc_fire, mem_fire;

  assign mem_fire  = mem_valid && mem_ready;
  assign acc_ready = (state_q == ST_IDLE) && (!mem_valid || mem_ready);
  assign acc_fire  = acc_valid && acc_ready;
  assign ind_done  = (state_q == ST_DATA_READ) && mem_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (acc_fire) begin
            mem_valid <= 1'b1;
            mem_addr  <= {sel_page, acc_offset};
            if (acc_kind == ACC_IND_RD) state_q <= ST_PTR_FETCH;
          end else if (mem_fire) begin
            mem_valid <= 1'b0;
          end
        end
        ST_PTR_FETCH: begin
          if (mem_fire) begin
            mem_addr <= {ind_page, mem_rdata};
            state_q  <= ST_DATA_READ;
          end
        end
        ST_DATA_READ: begin
          if (mem_fire) begin
            mem_valid <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr))); // R8

  AST_PTR_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PTR_FETCH && mem_fire) |=>
      (mem_valid && mem_addr == {$past(ind_page), $past(mem_rdata)})); // R6

  AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    ind_done |=> (!mem_valid && !ind_done)); // R7

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_kind == ACC_IND_RD) |=> !acc_ready); // R9

endmodule

// File: rtl/sram_page_mapper.sv
module sram_page_mapper
  import sram_pp_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int OFF_W  = 8,
  parameter int REG_W  = 8,
  parameter logic [REG_W-1:0] STK_ADDR = 8'hD1,
  parameter logic [REG_W-1:0] IDX_ADDR = 8'hD3,
  parameter logic [REG_W-1:0] IND_ADDR = 8'hD4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr_en,
  input  logic [REG_W-1:0]        reg_addr,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  input  logic                    acc_valid,
  output logic                    acc_ready,
  input  logic [2:0]              acc_kind,
  input  logic [OFF_W-1:0]        acc_offset,
  input  logic [1:0]              page_mode,
  input  logic [PAGE_W-1:0]       cur_page,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [PAGE_W+OFF_W-1:0] mem_addr,
  input  logic [OFF_W-1:0]        mem_rdata,
  output logic                    ind_done
);

  localparam int ADDR_W = PAGE_W + OFF_W;

  logic [PAGE_W-1:0] stk_page, idx_page, ind_page, sel_page;
  logic acc_fire;

  sram_pp_regs #(
    .PAGE_W(PAGE_W), .REG_W(REG_W),
    .STK_ADDR(STK_ADDR), .IDX_ADDR(IDX_ADDR), .IND_ADDR(IND_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .stk_page(stk_page), .idx_page(idx_page), .ind_page(ind_page)
  );

  sram_pp_select #(.PAGE_W(PAGE_W)) u_select (
    .kind(acc_kind), .mode(page_mode), .cur_page(cur_page),
    .stk_page(stk_page), .idx_page(idx_page), .page(sel_page)
  );

  sram_pp_seq #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_offset(acc_offset), .sel_page(sel_page), .ind_page(ind_page),
    .acc_ready(acc_ready), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .ind_done(ind_done)
  );

  assign acc_fire = acc_valid && acc_ready;

  AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_kind == ACC_STACK) |=>
      (mem_addr[ADDR_W-1:OFF_W] == $past(stk_page))); // R3

  AST_IDX_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_kind == ACC_SRC_IDX && page_mode == MODE_IDX_PAGE) |=>
      (mem_addr[ADDR_W-1:OFF_W] == $past(idx_page))); // R4

  AST_IND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_kind == ACC_IND_RD) |=>
      (mem_valid && mem_addr == {$past(cur_page), $past(acc_offset)})); // R6

  AST_DIRECT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_kind == ACC_DIRECT) |=>
      (mem_addr[ADDR_W-1:OFF_W] == $past(cur_page))); // R5

endmodule

// File: tb/sram_page_mapper_bench.sv
module sram_page_mapper_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [2:0]  acc_kind = '0;
  logic [7:0]  acc_offset = '0;
  logic [1:0]  page_mode = '0;
  logic [2:0]  cur_page = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [10:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        ind_done;

  int checks = 0;
  int errors = 0;
  logic [2:0] sh_stk = '0, sh_idx = '0, sh_ind = '0;

  always #2.5 clk = ~clk;

  sram_page_mapper u_sram_page_mapper (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_ready(acc_ready), .acc_kind(acc_kind), .acc_offset(acc_offset),
    .page_mode(page_mode), .cur_page(cur_page), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .ind_done(ind_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_page(input logic [2:0] kind, input logic [1:0] mode,
                                          input logic [2:0] cur);
    case (kind)
      3'd1: return sh_stk;
      3'd2, 3'd3: begin
        if (mode == 2'b10) return sh_idx;
        if (mode == 2'b11) return sh_stk;
        return 3'd0;
      end
      default: return cur;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] kind);
    case (kind)
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (a == 8'hD1) sh_stk = d[2:0];
    if (a == 8'hD3) sh_idx = d[2:0];
    if (a == 8'hD4) sh_ind = d[2:0];
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_check(input logic [7:0] a, input string req);
    logic [7:0] exp;
    @(negedge clk);
    reg_addr = a;
    #1;
    exp = (a == 8'hD1) ? {5'b0, sh_stk} : (a == 8'hD3) ? {5'b0, sh_idx} :
          (a == 8'hD4) ? {5'b0, sh_ind} : 8'h00;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  // one SRAM phase: stall randomly, then complete the handshake
  task automatic mem_phase(input logic [10:0] exp_addr, input string req,
                           input bit is_ind, input bit last, input logic [7:0] rd,
                           input bit stall_ok);
    bit rdy;
    forever begin
      @(negedge clk);
      rdy = stall_ok ? ($urandom_range(0, 2) != 0) : 1'b1;
      mem_ready = rdy;
      mem_rdata = rd;
      #1;
      chk(mem_valid == 1'b1, "R8", mem_valid, 1);
      chk(mem_addr == exp_addr, req, mem_addr, exp_addr);
      chk(acc_ready == (!is_ind && rdy), "R9", acc_ready, !is_ind && rdy);
      chk(ind_done == (is_ind && last && rdy), "R7", ind_done, is_ind && last && rdy);
      if (rdy) begin
        @(posedge clk);
        break;
      end
    end
    @(negedge clk);
    mem_ready = 1'b0;
  endtask

  task automatic do_access(input logic [2:0] kind, input logic [7:0] off,
                           input logic [1:0] mode, input logic [2:0] cur,
                           input logic [7:0] ptr, input bit stall_ok);
    logic [2:0] pg;
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = kind; acc_offset = off;
    page_mode = mode; cur_page = cur;
    #1;
    chk(acc_ready == 1'b1, "R9", acc_ready, 1);
    pg = exp_page(kind, mode, cur);
    @(posedge clk);
    #1;
    acc_valid = 1'b0;
    page_mode = ~mode;   // mode changes after acceptance must not matter
    if (kind == 3'd4) begin
      mem_phase({cur, off}, "R6", 1'b1, 1'b0, ptr, stall_ok);
      mem_phase({sh_ind, ptr}, "R6", 1'b1, 1'b1, ~ptr, stall_ok);
    end else begin
      mem_phase({pg, off}, req_of(kind), 1'b0, 1'b1, 8'h00, stall_ok);
    end
    #1;
    chk(mem_valid == 1'b0, "R8", mem_valid, 0);
    chk(ind_done == 1'b0, "R7", ind_done, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(posedge clk);
    #1;
    chk(mem_valid == 1'b0, "R1", mem_valid, 0);
    chk(ind_done == 1'b0, "R1", ind_done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    reg_check(8'hD1, "R1");
    reg_check(8'hD3, "R1");
    reg_check(8'hD4, "R1");

    // R2: register port, upper bits ignored, unmapped address inert
    reg_write(8'hD1, 8'hFD);
    reg_check(8'hD1, "R2");
    reg_write(8'hD3, 8'h0E);
    reg_check(8'hD3, "R2");
    reg_write(8'hD4, 8'hA3);
    reg_check(8'hD4, "R2");
    reg_write(8'hD2, 8'hFF);
    reg_check(8'hD2, "R2");
    reg_check(8'hD1, "R2");
    reg_check(8'hD3, "R2");
    reg_check(8'hD4, "R2");

    // R3: stack ignores mode; new pointer used on the very next access
    for (int m = 0; m < 4; m++) do_access(3'd1, 8'h7F, m[1:0], 3'd2, 8'h00, 1'b0);
    reg_write(8'hD1, 8'h02);
    do_access(3'd1, 8'hFF, 2'b10, 3'd7, 8'h00, 1'b0);

    // R4: indexed kinds under every mode
    for (int m = 0; m < 4; m++) begin
      do_access(3'd2, 8'h10, m[1:0], 3'd5, 8'h00, 1'b0);
      do_access(3'd3, 8'hE0, m[1:0], 3'd5, 8'h00, 1'b1);
    end

    // R5: direct and unused codes
    for (int k = 5; k < 8; k++) do_access(k[2:0], 8'h33, 2'b11, 3'd6, 8'h00, 1'b1);
    do_access(3'd0, 8'h00, 2'b10, 3'd1, 8'h00, 1'b0);

    // R6/R7: indirect read, mode has no effect
    do_access(3'd4, 8'h44, 2'b11, 3'd0, 8'hC5, 1'b0);
    do_access(3'd4, 8'hFF, 2'b10, 3'd7, 8'h00, 1'b1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        int s = $urandom_range(0, 2);
        reg_write(s == 0 ? 8'hD1 : s == 1 ? 8'hD3 : 8'hD4, 8'($urandom));
      end else begin
        do_access(3'($urandom), 8'($urandom), 2'($urandom), 3'($urandom),
                  8'($urandom), 1'b1);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule